// File: doc/BRIEF.md
# Flash Data Port Program and Read Controller

This block is the data-side memory-mapped slave of an on-chip flash controller. A host issues single-word program requests and single or incrementing burst read requests over a word-addressed port with 32-bit data, a burst count, a stall signal and a per-word read-valid strobe. Each request is validated against the populated address range and the per-sector protection inputs. The block then drives a behavioural flash array that sits behind it. This array holds a parameterised number of words, comes out of reset erased to all ones, and takes a fixed, parameterised number of cycles to program a word or to return read data.

While a program or read is in progress, and while an external erase is running, new requests are stalled. A two-bit busy code reports the operation in progress to the status logic. Two sticky flags report whether the last program and the last read succeeded. A failed read does not raise a bus error. The words it cannot deliver come back as erased data.

Top module: `fdp_ctrl`

## Requirements
- R1: After reset, with no request present, waitrequest and rdvalid are low, busy_code is 00, and rd_ok and wr_ok are both 0. Every array word reads as 32'hFFFF_FFFF.
- R2: A program with burstcount 1, an in-range address and an unprotected sector succeeds. The addressed word becomes old AND wdata, because programming can only clear bits. wr_ok becomes 1.
- R3: A program whose burstcount is not exactly 1 fails. No array word changes and wr_ok becomes 0.
- R4: A program fails if its address is at or above WORDS, or if its sector has the wp_mask bit or the fixed_prot bit set. No array word changes and wr_ok becomes 0. The sector of word address a is a / SECT_WORDS, and bit s of each mask belongs to sector s.
- R5: A program request seen while idle keeps waitrequest high for exactly PROG_LAT cycles, starting with the cycle in which it is first presented. waitrequest is low in the next cycle, where the write completes. busy_code is 10 in the stalled cycles after the first, and wr_ok shows the result in the cycle after completion.
- R6: A read presented while idle with no erase running is accepted in that same cycle (waitrequest low). It returns burstcount words from consecutive incrementing addresses, one per cycle, each marked by rdvalid. The first word arrives RD_LAT cycles after the accepting cycle. Burst counts from 1 to 128 are accepted.
- R7: From the cycle after acceptance until the cycle of the last rdvalid, busy_code is 11 and waitrequest is high. In the following cycle busy_code is 00.
- R8: A read word whose address is at or above WORDS, or whose sector has the fixed_prot bit set, is returned as 32'hFFFF_FFFF. Such a word makes rd_ok 0. A read with no such word makes rd_ok 1. rd_ok changes in the cycle after the last rdvalid.
- R9: A read with burstcount 0 or above 128 returns a single 32'hFFFF_FFFF word and makes rd_ok 0.
- R10: While erase_busy is high and no program or read is in progress, waitrequest is high, busy_code is 01, and no request is accepted.
- R11: rd_ok is unchanged by programs, and wr_ok is unchanged by reads.
- R12: A sector's wp_mask bit has no effect on reads of that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address of the request |
| rd | input | 1 | Read request |
| wr | input | 1 | Program request (takes priority over rd) |
| wdata | input | 32 | Program data |
| burstcount | input | BC_W | Number of words in the request |
| wp_mask | input | NUM_SECT | Per-sector write-protect bits |
| fixed_prot | input | NUM_SECT | Per-sector fixed protection bits (block programs and reads) |
| erase_busy | input | 1 | High while an erase is running elsewhere |
| waitrequest | output | 1 | Stall for the presented request |
| rdata | output | 32 | Read data |
| rdvalid | output | 1 | rdata holds a returned word |
| busy_code | output | 2 | 00 idle, 01 erase, 10 program, 11 read |
| rd_ok | output | 1 | Result of the last completed read |
| wr_ok | output | 1 | Result of the last completed program |

## Verification
A program result is due after a stall of exactly PROG_LAT cycles. The bench counts the falling edges on which waitrequest is high, then reads wr_ok one cycle after the stall ends and checks the data by later reads. For a read, the accepting cycle is taken as cycle zero. The bench expects rdvalid from cycle RD_LAT through cycle RD_LAT+n-1 and the new rd_ok in cycle RD_LAT+n, sampling every one of those cycles at the falling edge. Erase stalls and the flag-retention rules are checked cycle by cycle at the same sampling point.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROG = 2'd1,
    ST_READ = 2'd2
  } fdp_state_e;

  localparam logic [1:0] BUSY_IDLE  = 2'b00;
  localparam logic [1:0] BUSY_ERASE = 2'b01;
  localparam logic [1:0] BUSY_PROG  = 2'b10;
  localparam logic [1:0] BUSY_READ  = 2'b11;
endpackage

// File: rtl/fdp_guard.sv
module fdp_guard #(
  parameter int PW         = 9,
  parameter int WORDS      = 160,
  parameter int SECT_WORDS = 32,
  parameter int NUM_SECT   = 5,
  parameter bit CHECK_WP   = 1'b1
) (
  input  logic [PW-1:0]       ptr,
  input  logic [NUM_SECT-1:0] wp_mask,
  input  logic [NUM_SECT-1:0] fixed_prot,
  output logic                in_range,
  output logic                blocked
);
  logic wp_hit;
  logic fx_hit;

  always_comb begin
    wp_hit = 1'b0;
    fx_hit = 1'b0;
    for (int s = 0; s < NUM_SECT; s++) begin
      if (int'(ptr) >= s * SECT_WORDS && int'(ptr) < (s + 1) * SECT_WORDS) begin
        wp_hit = wp_hit | wp_mask[s];
        fx_hit = fx_hit | fixed_prot[s];
      end
    end
  end

  assign in_range = int'(ptr) < WORDS;

  generate
    if (CHECK_WP) begin : g_wp
      assign blocked = wp_hit | fx_hit;
    end else begin : g_nowp
      logic unused_wp;
      assign unused_wp = wp_hit;
      assign blocked   = fx_hit;
    end
  endgenerate
endmodule

// File: rtl/fdp_array.sv
module fdp_array #(
  parameter int WORDS = 160,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_en,
  input  logic [IW-1:0] pgm_idx,
  input  logic [DW-1:0] pgm_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (pgm_en) begin
      mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
    end
  end

  assign rd_data = (int'(rd_idx) < WORDS) ? mem[rd_idx] : '1;
endmodule

// File: rtl/fdp_ctrl.sv
module fdp_ctrl
  import fdp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WORDS      = 160,
  parameter int SECT_WORDS = 32,
  parameter int NUM_SECT   = 5,
  parameter int PROG_LAT   = 6,
  parameter int RD_LAT     = 3,
  parameter int MAX_BURST  = 128,
  parameter int BC_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  input  logic [31:0]         wdata,
  input  logic [BC_W-1:0]     burstcount,
  input  logic [NUM_SECT-1:0] wp_mask,
  input  logic [NUM_SECT-1:0] fixed_prot,
  input  logic                erase_busy,
  output logic                waitrequest,
  output logic [31:0]         rdata,
  output logic                rdvalid,
  output logic [1:0]          busy_code,
  output logic                rd_ok,
  output logic                wr_ok
);
  localparam int PW = ADDR_W + 1;
  localparam int IW = $clog2(WORDS);
  localparam int D  = RD_LAT - 1;
  localparam int CW = $clog2(MAX_BURST + RD_LAT + PROG_LAT + 1);
  localparam int RW = $clog2(MAX_BURST + 1);

  fdp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rem_q, rem_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic          wlegal_q, wlegal_d;
  logic          rbad_q, rbad_d;
  logic          force_q, force_d;
  logic          rd_ok_q, rd_ok_d;
  logic          wr_ok_q, wr_ok_d;

  logic          acc_in_range, acc_blocked;
  logic          cur_in_range, cur_blocked;
  logic          pgm_en;
  logic          issue;
  logic          word_bad;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] issue_data;
  logic          bc_ok;
  logic          wait_c;

  fdp_guard #(.PW(PW), .WORDS(WORDS), .SECT_WORDS(SECT_WORDS),
              .NUM_SECT(NUM_SECT), .CHECK_WP(1'b1)) u_acc_guard (
    .ptr(PW'(addr)), .wp_mask(wp_mask), .fixed_prot(fixed_prot),
    .in_range(acc_in_range), .blocked(acc_blocked)
  );

  fdp_guard #(.PW(PW), .WORDS(WORDS), .SECT_WORDS(SECT_WORDS),
              .NUM_SECT(NUM_SECT), .CHECK_WP(1'b0)) u_rd_guard (
    .ptr(ptr_q), .wp_mask(wp_mask), .fixed_prot(fixed_prot),
    .in_range(cur_in_range), .blocked(cur_blocked)
  );

  fdp_array #(.WORDS(WORDS), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .pgm_en(pgm_en), .pgm_idx(ptr_q[IW-1:0]), .pgm_data(wdat_q),
    .rd_idx(ptr_q[IW-1:0]), .rd_data(arr_data)
  );

  assign bc_ok      = (burstcount != '0) && (int'(burstcount) <= MAX_BURST);
  assign word_bad   = force_q | ~cur_in_range | cur_blocked;
  assign issue_data = word_bad ? '1 : arr_data;

  // next-state process
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    ptr_d    = ptr_q;
    wdat_d   = wdat_q;
    wlegal_d = wlegal_q;
    rbad_d   = rbad_q;
    force_d  = force_q;
    rd_ok_d  = rd_ok_q;
    wr_ok_d  = wr_ok_q;
    pgm_en   = 1'b0;
    issue    = 1'b0;
    wait_c   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        wait_c = erase_busy | wr;
        if (!erase_busy) begin
          if (wr) begin
            state_d  = ST_PROG;
            cnt_d    = CW'(PROG_LAT - 1);
            ptr_d    = PW'(addr);
            wdat_d   = wdata;
            wlegal_d = (burstcount == BC_W'(1)) & acc_in_range & ~acc_blocked;
          end else if (rd) begin
            state_d = ST_READ;
            rem_d   = bc_ok ? RW'(burstcount) : RW'(1);
            cnt_d   = (bc_ok ? CW'(burstcount) : CW'(1)) + CW'(D - 1);
            ptr_d   = PW'(addr);
            rbad_d  = ~bc_ok;
            force_d = ~bc_ok;
          end
        end
      end
      ST_PROG: begin
        wait_c = (cnt_q != '0);
        if (cnt_q == '0) begin
          pgm_en  = wlegal_q;
          wr_ok_d = wlegal_q;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_READ: begin
        wait_c = 1'b1;
        if (rem_q != '0) begin
          issue = 1'b1;
          rem_d = rem_q - RW'(1);
          ptr_d = ptr_q + PW'(1);
          if (word_bad) rbad_d = 1'b1;
        end
        if (cnt_q == '0) begin
          rd_ok_d = ~rbad_q;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rem_q    <= '0;
      ptr_q    <= '0;
      wdat_q   <= '0;
      wlegal_q <= 1'b0;
      rbad_q   <= 1'b0;
      force_q  <= 1'b0;
      rd_ok_q  <= 1'b0;
      wr_ok_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rem_q    <= rem_d;
      ptr_q    <= ptr_d;
      wdat_q   <= wdat_d;
      wlegal_q <= wlegal_d;
      rbad_q   <= rbad_d;
      force_q  <= force_d;
      rd_ok_q  <= rd_ok_d;
      wr_ok_q  <= wr_ok_d;
    end
  end

  // read return pipeline: D stages after the issue cycle
  generate
    for (genvar k = 0; k < D; k++) begin : g_pipe
      logic          v_q;
      logic [DW-1:0] d_q;
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
          end else begin
            v_q <= issue;
            if (issue) d_q <= issue_data;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
          end else begin
            v_q <= g_pipe[k-1].v_q;
            if (g_pipe[k-1].v_q) d_q <= g_pipe[k-1].d_q;
          end
        end
      end
    end
  endgenerate

  assign rdvalid     = g_pipe[D-1].v_q;
  assign rdata       = g_pipe[D-1].d_q;
  assign waitrequest = wait_c;
  assign rd_ok       = rd_ok_q;
  assign wr_ok       = wr_ok_q;

  always_comb begin
    unique case (state_q)
      ST_PROG: busy_code = BUSY_PROG;
      ST_READ: busy_code = BUSY_READ;
      default: busy_code = erase_busy ? BUSY_ERASE : BUSY_IDLE;
    endcase
  end
endmodule

// File: rtl/fdp_ctrl_chk.sv
module fdp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       waitrequest,
  input logic       rdvalid,
  input logic [1:0] busy_code,
  input logic       rd_ok,
  input logic       wr_ok,
  input logic       erase_busy
);
  // R7: returned words only appear during a read
  a_r7_valid_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdvalid |-> busy_code == 2'b11);

  // R7: a read in progress stalls the port
  a_r7_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    busy_code == 2'b11 |-> waitrequest);

  // R10: erase while idle stalls the port
  a_r10_erase_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && busy_code != 2'b10 && busy_code != 2'b11) |-> waitrequest);

  // R10: erase code only while erase input is high
  a_r10_erase_code: assert property (@(posedge clk) disable iff (!rst_n)
    busy_code == 2'b01 |-> erase_busy);

  // R11: wr_ok only moves at the end of a program
  a_r11_wrok_by_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ok) |-> $past(busy_code) == 2'b10);

  // R11: rd_ok only moves at the end of a read
  a_r11_rdok_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_ok) |-> $past(busy_code) == 2'b11);

  // R5: program state follows a stalled cycle
  a_r5_prog_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_code == 2'b10) |-> $past(waitrequest));
endmodule

bind fdp_ctrl fdp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .waitrequest(waitrequest), .rdvalid(rdvalid),
  .busy_code(busy_code), .rd_ok(rd_ok), .wr_ok(wr_ok), .erase_busy(erase_busy)
);

// File: tb/fdp_ctrl_tb_top.sv
module fdp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int WORDS      = 160;
  localparam int SW         = 32;
  localparam int NS         = 5;
  localparam int PROG_LAT   = 6;
  localparam int RD_LAT     = 3;
  localparam int MAXB       = 128;
  localparam int BC_W       = 8;
  localparam int WATCHDOG   = 100000;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_i;
  logic              rd_i, wr_i;
  logic [31:0]       wdata_i;
  logic [BC_W-1:0]   bc_i;
  logic [NS-1:0]     wp_i, fp_i;
  logic              erase_i;
  logic              wait_o;
  logic [31:0]       rdata_o;
  logic              rdvalid_o;
  logic [1:0]        busy_o;
  logic              rd_ok_o, wr_ok_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];

  fdp_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .SECT_WORDS(SW), .NUM_SECT(NS),
             .PROG_LAT(PROG_LAT), .RD_LAT(RD_LAT), .MAX_BURST(MAXB), .BC_W(BC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr_i), .rd(rd_i), .wr(wr_i), .wdata(wdata_i),
    .burstcount(bc_i), .wp_mask(wp_i), .fixed_prot(fp_i), .erase_busy(erase_i),
    .waitrequest(wait_o), .rdata(rdata_o), .rdvalid(rdvalid_o), .busy_code(busy_o),
    .rd_ok(rd_ok_o), .wr_ok(wr_ok_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit prog_legal(input int a, input int bc);
    if (bc != 1 || a >= WORDS) return 1'b0;
    return !(wp_i[a / SW] || fp_i[a / SW]);
  endfunction

  function automatic bit word_good(input int p);
    if (p >= WORDS) return 1'b0;
    return !fp_i[p / SW];
  endfunction

  function automatic logic [31:0] exp_word(input int p);
    return word_good(p) ? model[p] : 32'hFFFF_FFFF;
  endfunction

  task automatic do_write(input int a, input logic [31:0] d, input int bc, input string req);
    bit legal;
    int hi;
    legal = prog_legal(a, bc);
    @(negedge clk);
    addr_i = ADDR_W'(a); wdata_i = d; bc_i = BC_W'(bc); wr_i = 1'b1; rd_i = 1'b0;
    #1;
    hi = 0;
    while (wait_o) begin
      if (hi == 1) check_eq("R5", "busy code while programming", 32'(busy_o), 32'h2);
      hi++;
      @(negedge clk); #1;
    end
    check_eq("R5", "program stall cycles", hi, PROG_LAT);
    @(negedge clk);
    wr_i = 1'b0;
    #1;
    check_eq(req, "wr_ok after program", 32'(wr_ok_o), 32'(legal));
    if (legal) model[a] = model[a] & d;
  endtask

  task automatic do_read(input int a, input int bc, input string req);
    int n;
    bit ok;
    bc_ok_calc: begin
      ok = (bc >= 1 && bc <= MAXB);
      n  = ok ? bc : 1;
    end
    for (int i = 0; i < n; i++) if (!ok || !word_good(a + i)) ok = 1'b0;
    @(negedge clk);
    erase_i = 1'b0;
    addr_i = ADDR_W'(a); bc_i = BC_W'(bc); rd_i = 1'b1; wr_i = 1'b0;
    #1;
    check_eq("R6", "read accepted without stall", 32'(wait_o), 32'h0);
    for (int j = 1; j <= RD_LAT + n; j++) begin
      @(negedge clk);
      rd_i = 1'b0;
      #1;
      if (j < RD_LAT + n) begin
        check_eq("R7", "busy code during read", 32'(busy_o), 32'h3);
        check_eq("R7", "stall during read", 32'(wait_o), 32'h1);
      end
      if (j >= RD_LAT && j < RD_LAT + n) begin
        check_eq("R6", "rdvalid for burst word", 32'(rdvalid_o), 32'h1);
        if (bc >= 1 && bc <= MAXB)
          check_eq(req, "read word", rdata_o, exp_word(a + j - RD_LAT));
        else
          check_eq("R9", "read word for bad count", rdata_o, 32'hFFFF_FFFF);
      end else begin
        check_eq("R6", "rdvalid outside window", 32'(rdvalid_o), 32'h0);
      end
    end
    check_eq("R7", "busy code after read", 32'(busy_o), 32'h0);
    check_eq((bc >= 1 && bc <= MAXB) ? "R8" : "R9", "rd_ok after read", 32'(rd_ok_o), 32'(ok));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic sav;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) model[i] = 32'hFFFF_FFFF;
    rst_n = 1'b0; addr_i = '0; rd_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    bc_i = '0; wp_i = '0; fp_i = '0; erase_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_eq("R1", "waitrequest after reset", 32'(wait_o), 32'h0);
    check_eq("R1", "rdvalid after reset", 32'(rdvalid_o), 32'h0);
    check_eq("R1", "busy after reset", 32'(busy_o), 32'h0);
    check_eq("R1", "rd_ok after reset", 32'(rd_ok_o), 32'h0);
    check_eq("R1", "wr_ok after reset", 32'(wr_ok_o), 32'h0);
    do_read(0, 1, "R1");

    do_write(5, 32'hA5A5_0F0F, 1, "R2");
    do_read(5, 1, "R2");
    do_write(5, 32'hFF00_FFFF, 1, "R2");
    check_eq("R2", "model and-merge", model[5], 32'hA500_0F0F);
    do_read(4, 3, "R2");

    do_write(6, 32'h0000_0000, 2, "R3");
    do_write(7, 32'h1234_5678, 0, "R3");
    do_read(6, 2, "R3");

    do_write(170, 32'h0, 1, "R4");
    wp_i = 5'b00010;
    do_write(40, 32'h0, 1, "R4");
    do_read(40, 2, "R12");
    wp_i = '0;
    fp_i = 5'b00100;
    do_write(70, 32'h0, 1, "R4");
    do_read(70, 1, "R8");
    // R11: a successful program leaves the failed read flag alone
    do_write(3, 32'h0F0F_0000, 1, "R2");
    check_eq("R11", "rd_ok kept across program", 32'(rd_ok_o), 32'h0);
    fp_i = '0;
    do_read(3, 1, "R2");
    do_write(2, 32'h0, 3, "R3");
    check_eq("R11", "rd_ok kept across failed program", 32'(rd_ok_o), 32'h1);
    sav = wr_ok_o;
    do_read(1, 2, "R6");
    check_eq("R11", "wr_ok kept across read", 32'(wr_ok_o), 32'(sav));

    do_read(155, 8, "R8");
    do_read(0, MAXB, "R6");
    do_read(10, 0, "R9");
    do_read(10, 200, "R9");
    do_read(10, MAXB + 1, "R9");

    // R10: erase in progress holds off a read
    @(negedge clk);
    erase_i = 1'b1; addr_i = ADDR_W'(5); bc_i = BC_W'(1); rd_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check_eq("R10", "stall during erase", 32'(wait_o), 32'h1);
      check_eq("R10", "busy code during erase", 32'(busy_o), 32'h1);
      check_eq("R10", "no data during erase", 32'(rdvalid_o), 32'h0);
      @(negedge clk);
    end
    do_read(5, 1, "R10");

    for (int it = 0; it < 60; it++) begin
      int a;
      int bc;
      a  = int'($urandom % (WORDS + 16));
      wp_i = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      fp_i = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      if (($urandom % 2) == 0) begin
        bc = (($urandom % 5) == 0) ? int'($urandom % 3) : 1;
        do_write(a, $urandom, bc, prog_legal(a, bc) ? "R2" : (bc != 1 ? "R3" : "R4"));
      end else begin
        bc = 1 + int'($urandom % 10);
        do_read(a, bc, "R8");
      end
    end
    summary();
    $finish;
  end
endmodule